// File: doc/BRIEF.md
# Scatter Segment PRD Splitter

This block turns a list of memory segments, each given as a 32-bit bus address and a byte length, into physical region descriptor entries for a bus-master disk DMA engine. Each entry leaves the block as two 32-bit words on a valid/ready stream. The address word comes first. The control word follows and carries the byte count and, in the normal format, an end-of-table flag. No entry spans a 64 KiB address boundary. The block holds back the most recent entry until it knows whether another entry follows, so it can set the end flag on the true final entry.

Two configuration inputs choose the count encoding and a workaround for hosts that read a zero 16-bit count as zero bytes rather than 64 KiB. When the request ends, the block gives a single-cycle done pulse with the number of entries built. If the request overflows the table or produces no entries, it gives an error code instead. On an error the software must transfer the data with programmed I/O, and it discards any words already emitted for that request.

Top module: `prd_splitter`

## Requirements
- R1: After reset, seg_ready is 1 and word_valid and req_done are 0.
- R2: No entry spans a 64 KiB boundary. Each chunk is 0x10000 minus the low 16 bits of the current address, capped at the bytes left in the segment.
- R3: In the normal format (cfg_dword_fmt=0), control word bits [15:0] hold the low 16 bits of the chunk size, so a 64 KiB chunk is encoded as 0x0000.
- R4: Each entry is emitted as the address word followed by the control word. In the normal format, control bit 31 is 1 on the last entry of a request and 0 on every other entry.
- R5: With cfg_split_full=1 in the normal format, a chunk whose size is 64 KiB is emitted as two 0x8000-byte entries, at addresses A and A+0x8000.
- R6: With cfg_dword_fmt=1, the control word is ((bytes>>2)-1)<<16 and bit 31 is never used as an end flag. The 64 KiB workaround does not apply in this format.
- R7: A segment with zero length emits nothing, and it affects neither the entry count nor which entry carries the end flag.
- R8: If a request ends with no entries built, req_done reports req_err=1 and req_count=0.
- R9: Building entry MAX_ENTRIES+1 aborts the request. req_err=2 and req_count=0 are reported once the segment marked last has been accepted, and the segments in between are consumed without output. A request of exactly MAX_ENTRIES entries succeeds.
- R10: The extra entry created by the R5 workaround counts toward MAX_ENTRIES.
- R11: While word_valid=1 and word_ready=0, word_valid and word_data stay unchanged.
- R12: A successful request gives req_done high for exactly one cycle, with req_err=0 and req_count equal to the number of entries emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_dword_fmt | input | 1 | 1 selects the dword-count control format; held stable during a request |
| cfg_split_full | input | 1 | 1 enables the two-half workaround for 64 KiB chunks; held stable during a request |
| seg_valid | input | 1 | Segment offered |
| seg_ready | output | 1 | Segment accepted when high together with seg_valid |
| seg_addr | input | ADDR_W (32) | Segment bus address |
| seg_len | input | LEN_W (32) | Segment length in bytes |
| seg_last | input | 1 | Marks the final segment of a request |
| word_valid | output | 1 | Descriptor word available |
| word_ready | input | 1 | Sink takes the word |
| word_data | output | ADDR_W (32) | Address word or control word |
| req_done | output | 1 | One-cycle end-of-request pulse |
| req_count | output | CNT_W (4) | Entries built; 0 on error |
| req_err | output | 2 | 0 success, 1 empty table, 2 overflow |

## Verification
The latency from a segment handshake to the first descriptor word depends on how many chunks the segment yields and on back-pressure, so the bench does not wait a fixed number of cycles. It drives inputs on the falling edge. It counts a word only on a falling edge where word_valid and word_ready are both high, and the bench's own ready register holds that value through the next rising edge. The done pulse is registered and lasts a single cycle. The bench latches it on the falling edge where it is seen and polls for it within a bounded window, so a missing or late result shows up as a missing word or a missing done.

// File: rtl/prd_pkg.sv
package prd_pkg;

    typedef enum logic [1:0] {
        ERR_NONE     = 2'd0,
        ERR_EMPTY    = 2'd1,
        ERR_OVERFLOW = 2'd2
    } prd_err_e;

    typedef enum logic [2:0] {
        ST_ACCEPT = 3'd0,
        ST_SPLIT  = 3'd1,
        ST_OUT    = 3'd2,
        ST_FINISH = 3'd3,
        ST_DRAIN  = 3'd4,
        ST_DONE   = 3'd5
    } prd_state_e;

endpackage

// File: rtl/prd_chunk_sizer.sv
module prd_chunk_sizer #(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned LEN_W    = 32,
    parameter int unsigned BND_BITS = 16
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic [LEN_W-1:0]    remaining,
    input  logic                split_full,
    input  logic                dword_fmt,
    output logic [BND_BITS:0]   chunk
);
    localparam int unsigned CH_W = BND_BITS + 1;
    localparam logic [CH_W-1:0] FULL = {1'b1, {BND_BITS{1'b0}}};
    localparam logic [CH_W-1:0] HALF = {2'b01, {(BND_BITS-1){1'b0}}};

    logic [CH_W-1:0] room;
    logic [CH_W-1:0] capped;

    always_comb begin
        // bytes left before the next boundary
        room = FULL - {1'b0, addr[BND_BITS-1:0]};
        if (remaining < {{(LEN_W-CH_W){1'b0}}, room}) begin
            capped = remaining[CH_W-1:0];
        end else begin
            capped = room;
        end
        // a full-window chunk becomes a half chunk; the next cycle naturally
        // yields the second half because the address then sits mid-window
        if (split_full && !dword_fmt && capped == FULL) begin
            chunk = HALF;
        end else begin
            chunk = capped;
        end
    end
endmodule

// File: rtl/prd_ctrl_encoder.sv
module prd_ctrl_encoder #(
    parameter int unsigned BND_BITS = 16,
    parameter int unsigned WORD_W   = 32
) (
    input  logic [BND_BITS:0]   bytes,
    input  logic                end_flag,
    input  logic                dword_fmt,
    output logic [WORD_W-1:0]   ctrl
);
    logic [BND_BITS:0] dw_minus1;

    always_comb begin
        dw_minus1 = (bytes >> 2) - 1'b1;
        ctrl      = '0;
        if (dword_fmt) begin
            // dword count minus one in the upper half, no terminator bit
            ctrl = {{(WORD_W-BND_BITS-1){1'b0}}, dw_minus1} << BND_BITS;
        end else begin
            ctrl[BND_BITS-1:0] = bytes[BND_BITS-1:0];
            ctrl[WORD_W-1]     = end_flag;
        end
    end
endmodule

// File: rtl/prd_splitter.sv
module prd_splitter
    import prd_pkg::*;
#(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned LEN_W       = 32,
    parameter int unsigned BND_BITS    = 16,
    parameter int unsigned MAX_ENTRIES = 8,
    parameter int unsigned CNT_W       = $clog2(MAX_ENTRIES + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_dword_fmt,
    input  logic                cfg_split_full,
    input  logic                seg_valid,
    output logic                seg_ready,
    input  logic [ADDR_W-1:0]   seg_addr,
    input  logic [LEN_W-1:0]    seg_len,
    input  logic                seg_last,
    output logic                word_valid,
    input  logic                word_ready,
    output logic [ADDR_W-1:0]   word_data,
    output logic                req_done,
    output logic [CNT_W-1:0]    req_count,
    output logic [1:0]          req_err
);
    localparam int unsigned CH_W = BND_BITS + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_ENTRIES);
    localparam logic [CH_W-1:0]  FULL    = {1'b1, {BND_BITS{1'b0}}};

    typedef struct packed {
        prd_state_e         st;
        logic [ADDR_W-1:0]  addr;
        logic [LEN_W-1:0]   rem;
        logic               last;
        logic               pend_v;
        logic [ADDR_W-1:0]  pend_addr;
        logic [CH_W-1:0]    pend_bytes;
        logic               pend_end;
        logic               phase;
        logic [CNT_W-1:0]   cnt;
        logic               done;
        logic [CNT_W-1:0]   done_cnt;
        prd_err_e           err;
        prd_err_e           done_err;
    } state_t;

    state_t q, d;

    logic [CH_W-1:0]   chunk;
    logic [ADDR_W-1:0] ctrl_word;

    prd_chunk_sizer #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BND_BITS(BND_BITS)
    ) sizer_i (
        .addr(q.addr), .remaining(q.rem),
        .split_full(cfg_split_full), .dword_fmt(cfg_dword_fmt),
        .chunk(chunk)
    );

    prd_ctrl_encoder #(
        .BND_BITS(BND_BITS), .WORD_W(ADDR_W)
    ) enc_i (
        .bytes(q.pend_bytes), .end_flag(q.pend_end),
        .dword_fmt(cfg_dword_fmt), .ctrl(ctrl_word)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            ST_ACCEPT: begin
                if (seg_valid) begin
                    if (seg_len == '0) begin
                        if (seg_last) d.st = ST_FINISH;
                    end else begin
                        d.addr = seg_addr;
                        d.rem  = seg_len;
                        d.last = seg_last;
                        d.st   = ST_SPLIT;
                    end
                end
            end
            ST_SPLIT: begin
                if (q.pend_v) begin
                    // older entry is known not to be the last: send it first
                    d.phase = 1'b0;
                    d.st    = ST_OUT;
                end else if (q.cnt == CNT_MAX) begin
                    d.err = ERR_OVERFLOW;
                    d.st  = q.last ? ST_DONE : ST_DRAIN;
                end else begin
                    d.pend_v     = 1'b1;
                    d.pend_addr  = q.addr;
                    d.pend_bytes = chunk;
                    d.pend_end   = 1'b0;
                    d.cnt        = q.cnt + 1'b1;
                    d.addr       = q.addr + {{(ADDR_W-CH_W){1'b0}}, chunk};
                    d.rem        = q.rem - {{(LEN_W-CH_W){1'b0}}, chunk};
                    if (q.rem == {{(LEN_W-CH_W){1'b0}}, chunk}) begin
                        d.st = q.last ? ST_FINISH : ST_ACCEPT;
                    end
                end
            end
            ST_OUT: begin
                if (word_ready) begin
                    if (!q.phase) begin
                        d.phase = 1'b1;
                    end else begin
                        d.phase  = 1'b0;
                        d.pend_v = 1'b0;
                        d.st     = q.pend_end ? ST_DONE : ST_SPLIT;
                    end
                end
            end
            ST_FINISH: begin
                if (q.cnt == '0) begin
                    d.err = ERR_EMPTY;
                    d.st  = ST_DONE;
                end else begin
                    d.pend_end = 1'b1;
                    d.phase    = 1'b0;
                    d.st       = ST_OUT;
                end
            end
            ST_DRAIN: begin
                if (seg_valid && seg_last) d.st = ST_DONE;
            end
            ST_DONE: begin
                d.done     = 1'b1;
                d.done_cnt = (q.err == ERR_NONE) ? q.cnt : '0;
                d.done_err = q.err;
                d.err      = ERR_NONE;
                d.cnt      = '0;
                d.pend_v   = 1'b0;
                d.pend_end = 1'b0;
                d.st       = ST_ACCEPT;
            end
            default: d.st = ST_ACCEPT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign seg_ready  = (q.st == ST_ACCEPT) || (q.st == ST_DRAIN);
    assign word_valid = (q.st == ST_OUT);
    assign word_data  = q.phase ? ctrl_word : q.pend_addr;
    assign req_done   = q.done;
    assign req_count  = q.done_cnt;
    assign req_err    = q.done_err;

    // R11: word held under back-pressure
    p_word_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid && !word_ready |=> word_valid && $stable(word_data));

    // R12: done is a single-cycle pulse
    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |=> !req_done);

    // R9: an error result never reports entries
    p_err_zero_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_done && req_err != 2'd0 |-> req_count == '0);

    // R2: a staged entry stays inside one 64 KiB window
    p_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        q.pend_v |-> ({2'b00, q.pend_addr[BND_BITS-1:0]} + {1'b0, q.pend_bytes})
                     <= {1'b0, FULL});

    // R5: with the workaround on, no staged entry is a full window
    p_no_full_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        q.pend_v && cfg_split_full && !cfg_dword_fmt |-> q.pend_bytes != FULL);

    // R10: entry counter never passes the table limit
    p_count_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CNT_MAX);
endmodule

// File: tb/prd_splitter_tb.sv
`timescale 1ns/1ps
module prd_splitter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_dword_fmt = 1'b0;
    logic        cfg_split_full = 1'b0;
    logic        seg_valid = 1'b0;
    logic        seg_ready;
    logic [31:0] seg_addr = '0;
    logic [31:0] seg_len = '0;
    logic        seg_last = 1'b0;
    logic        word_valid;
    logic        word_ready;
    logic [31:0] word_data;
    logic        req_done;
    logic [3:0]  req_count;
    logic [1:0]  req_err;

    always #2.5 clk = ~clk;

    prd_splitter dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_dword_fmt(cfg_dword_fmt), .cfg_split_full(cfg_split_full),
        .seg_valid(seg_valid), .seg_ready(seg_ready),
        .seg_addr(seg_addr), .seg_len(seg_len), .seg_last(seg_last),
        .word_valid(word_valid), .word_ready(word_ready), .word_data(word_data),
        .req_done(req_done), .req_count(req_count), .req_err(req_err)
    );

    int tests = 0;
    int fails = 0;
    logic bp_mode = 1'b0;
    logic rdy_q = 1'b1;
    int   bp_ctr = 0;

    always @(posedge clk) begin
        bp_ctr <= bp_ctr + 1;
        rdy_q  <= bp_mode ? (bp_ctr % 3 == 0) : 1'b1;
    end
    assign word_ready = rdy_q;

    logic [31:0] got_w [0:31];
    int          got_n = 0;
    logic        done_seen = 1'b0;
    logic [3:0]  done_cnt = '0;
    logic [1:0]  done_err = '0;

    always @(negedge clk) begin
        if (word_valid && word_ready) begin
            if (got_n < 32) got_w[got_n] = word_data;
            got_n = got_n + 1;
        end
        if (req_done) begin
            done_seen = 1'b1;
            done_cnt  = req_count;
            done_err  = req_err;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic clear_capture();
        got_n     = 0;
        done_seen = 1'b0;
    endtask

    task automatic send_seg(input logic [31:0] a, input logic [31:0] l, input logic lst);
        seg_addr  = a;
        seg_len   = l;
        seg_last  = lst;
        seg_valid = 1'b1;
        while (!seg_ready) @(negedge clk);
        @(negedge clk);
        seg_valid = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        for (int i = 0; i < 3000 && !done_seen; i++) @(negedge clk);
        check({tag, " done seen"}, {31'd0, done_seen}, 32'd1);
        repeat (3) @(negedge clk);
    endtask

    task automatic check_word(input string tag, input int idx, input logic [31:0] exp);
        check($sformatf("%s word%0d", tag, idx), (idx < got_n && idx < 32) ? got_w[idx] : 32'hDEAD_BEEF, exp);
    endtask

    task automatic t_reset();
        check("R1 seg_ready", {31'd0, seg_ready}, 32'd1);
        check("R1 word_valid", {31'd0, word_valid}, 32'd0);
        check("R1 req_done", {31'd0, req_done}, 32'd0);
    endtask

    task automatic t_single();
        clear_capture();
        send_seg(32'h1000_0000, 32'h200, 1'b1);
        wait_done("R12 single");
        check("R4 single nwords", got_n, 2);
        check_word("R4 single", 0, 32'h1000_0000);
        check_word("R3 single", 1, 32'h8000_0200);
        check("R12 single count", {28'd0, done_cnt}, 32'd1);
        check("R12 single err", {30'd0, done_err}, 32'd0);
    endtask

    task automatic t_cross(input string tag);
        clear_capture();
        send_seg(32'h0001_FF00, 32'h300, 1'b1);
        wait_done(tag);
        check({tag, " nwords"}, got_n, 4);
        check_word(tag, 0, 32'h0001_FF00);
        check_word(tag, 1, 32'h0000_0100);
        check_word(tag, 2, 32'h0002_0000);
        check_word(tag, 3, 32'h8000_0200);
        check({tag, " count"}, {28'd0, done_cnt}, 32'd2);
    endtask

    task automatic t_full_plain();
        clear_capture();
        send_seg(32'h0003_0000, 32'h1_0000, 1'b1);
        wait_done("R3 full");
        check("R3 full nwords", got_n, 2);
        check_word("R3 full", 0, 32'h0003_0000);
        check_word("R3 full", 1, 32'h8000_0000);
    endtask

    task automatic t_full_split();
        cfg_split_full = 1'b1;
        clear_capture();
        send_seg(32'h0003_0000, 32'h1_0000, 1'b1);
        wait_done("R5 split");
        check("R5 split nwords", got_n, 4);
        check_word("R5 split", 0, 32'h0003_0000);
        check_word("R5 split", 1, 32'h0000_8000);
        check_word("R5 split", 2, 32'h0003_8000);
        check_word("R5 split", 3, 32'h8000_8000);
        check("R10 split count", {28'd0, done_cnt}, 32'd2);
        cfg_split_full = 1'b0;
    endtask

    task automatic t_dword();
        cfg_dword_fmt  = 1'b1;
        cfg_split_full = 1'b1;
        clear_capture();
        send_seg(32'h0004_0000, 32'h1_0000, 1'b0);
        send_seg(32'h0005_0000, 32'h100, 1'b1);
        wait_done("R6 dword");
        check("R6 dword nwords", got_n, 4);
        check_word("R6 dword", 0, 32'h0004_0000);
        check_word("R6 dword", 1, 32'h3FFF_0000);
        check_word("R6 dword", 2, 32'h0005_0000);
        check_word("R6 dword", 3, 32'h003F_0000);
        cfg_dword_fmt  = 1'b0;
        cfg_split_full = 1'b0;
    endtask

    task automatic t_zero_skip();
        clear_capture();
        send_seg(32'h0000_0100, 32'h10, 1'b0);
        send_seg(32'h0000_0200, 32'h0, 1'b0);
        send_seg(32'h0000_0300, 32'h20, 1'b1);
        wait_done("R7 skip");
        check("R7 skip nwords", got_n, 4);
        check_word("R7 skip", 0, 32'h0000_0100);
        check_word("R4 mid", 1, 32'h0000_0010);
        check_word("R7 skip", 2, 32'h0000_0300);
        check_word("R4 end", 3, 32'h8000_0020);
        check("R7 skip count", {28'd0, done_cnt}, 32'd2);
    endtask

    task automatic t_empty();
        clear_capture();
        send_seg(32'h0000_0000, 32'h0, 1'b1);
        wait_done("R8 empty");
        check("R8 empty nwords", got_n, 0);
        check("R8 empty err", {30'd0, done_err}, 32'd1);
        check("R8 empty count", {28'd0, done_cnt}, 32'd0);
    endtask

    task automatic t_limit();
        clear_capture();
        send_seg(32'h0000_0000, 32'h8_0000, 1'b1);
        wait_done("R9 exact");
        check("R9 exact err", {30'd0, done_err}, 32'd0);
        check("R9 exact count", {28'd0, done_cnt}, 32'd8);
        check_word("R9 exact last", 15, 32'h8000_0000);
        clear_capture();
        send_seg(32'h0000_0000, 32'h9_0000, 1'b0);
        send_seg(32'h0100_0000, 32'h40, 1'b1);
        wait_done("R9 over");
        check("R9 over err", {30'd0, done_err}, 32'd2);
        check("R9 over count", {28'd0, done_cnt}, 32'd0);
    endtask

    task automatic t_split_limit();
        cfg_split_full = 1'b1;
        clear_capture();
        send_seg(32'h0000_0000, 32'h4_0000, 1'b1);
        wait_done("R10 fit");
        check("R10 fit count", {28'd0, done_cnt}, 32'd8);
        clear_capture();
        send_seg(32'h0000_0000, 32'h5_0000, 1'b1);
        wait_done("R10 over");
        check("R10 over err", {30'd0, done_err}, 32'd2);
        check("R10 over count", {28'd0, done_cnt}, 32'd0);
        cfg_split_full = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_cross("R2 cross");
        t_full_plain();
        t_full_split();
        t_dword();
        t_zero_skip();
        t_empty();
        t_limit();
        t_split_limit();
        bp_mode = 1'b1;
        t_cross("R11 backpressure");
        bp_mode = 1'b0;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(5ns * 150000);
        tests++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule